// File: doc/BRIEF.md
# Multi-mode alert and interrupt status controller

This block collects out-of-range results from a system monitor's measurement loop and turns them into a small interrupt status register and an active-low alert line. Four voltage channels and one temperature channel feed it. A measurement strobe marks each completed conversion. With that strobe the block receives a flag for each voltage channel and the signed temperature sample. It compares the sample against a hot limit and a hysteresis limit, and the chosen temperature policy decides whether a fault is raised.

A host reads the status through a read strobe, which clears latched bits. A mask register hides individual channels from both the status and the alert. A global enable and an alert-clear control act on the alert line only. The measurement loop keeps running whatever the alert state is. The block owns no bus logic and no conversion sequencing.

Top module: `alert_status_ctrl`

## Requirements
- R1: `status` bit 0..3 hold voltage channels 0..3 and bit 4 holds temperature. Bits 7..5 always read 0. A voltage flag present with `meas_valid` sets its status bit on that clock edge, and the bit stays latched.
- R2: A `stat_rd` pulse clears every latched status bit on its edge, except bit 4 in comparator mode. A fault that arrives in the same cycle as the read wins, and its bit stays set.
- R3: When `mask` bit i is 1, a fault cannot set status bit i, an already latched bit i reads 0, and channel i cannot drive the alert. Clearing the mask bit shows a latched bit again. `mask_wdata` is loaded into `mask` by `mask_wr`.
- R4: `alert_n` is low only while `alert_en` is 1 and at least one unmasked alert is pending. Dropping `alert_en` raises `alert_n` at once and does not change `status`.
- R5: While `alert_clr` is 1, `alert_n` is high and pending alerts are discarded. Status contents are left unchanged. A fault that is still present asserts the alert again at the next measurement.
- R6: Default mode (`temp_mode` 00). The limits and the sample are signed two's complement. A sample strictly above `hot_lim` raises the temperature fault. Later samples keep raising it until a sample falls strictly below `hyst_lim`.
- R7: One-time mode (`temp_mode` 01). The first sample above `hot_lim` raises one fault. No further fault is raised until a sample falls strictly below `hyst_lim`, which raises one fault again.
- R8: Comparator mode (`temp_mode` 10). Each measurement sets status bit 4 and its alert to (sample > `hot_lim`). A read leaves bit 4 unchanged.
- R9: `temp_mode` 11 behaves exactly as default mode.
- R10: After reset `status` is 0, `mask` is 0 and `alert_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | One-cycle strobe: a conversion result is present |
| volt_oor | input | 4 | Per-channel voltage out-of-range flags, valid with meas_valid |
| temp | input | 8 | Signed temperature sample, valid with meas_valid |
| hot_lim | input | 8 | Signed hot limit |
| hyst_lim | input | 8 | Signed hysteresis limit |
| temp_mode | input | 2 | Temperature policy: 00 default, 01 one-time, 10 comparator, 11 default |
| stat_rd | input | 1 | Status read strobe (read-to-clear) |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 5 | Mask write data |
| alert_en | input | 1 | Global alert enable |
| alert_clr | input | 1 | Alert clear control |
| status | output | 8 | Interrupt status register |
| mask | output | 5 | Mask register contents |
| alert_n | output | 1 | Active-low alert |

## Verification
Status bits and the mask follow their strobe by one clock edge, so the bench applies each vector before an edge and compares a few nanoseconds after that edge. Mask changes affect `alert_n` on that same edge. `alert_en` and `alert_clr` reach `alert_n` without any register, so those checks are taken within the same cycle, before the next edge. The vector table walks each temperature policy through hot, band and cold samples, so every hysteresis decision falls on a known measurement edge.

// File: rtl/alert_status_ctrl.sv
module alert_status_ctrl #(
  parameter int TW = 8,
  parameter int NV = 4,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_valid,
  input  logic [NV-1:0] volt_oor,
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] hot_lim,
  input  logic [TW-1:0] hyst_lim,
  input  logic [1:0]    temp_mode,
  input  logic          stat_rd,
  input  logic          mask_wr,
  input  logic [NV:0]   mask_wdata,
  input  logic          alert_en,
  input  logic          alert_clr,
  output logic [SW-1:0] status,
  output logic [NV:0]   mask,
  output logic          alert_n
);
  localparam int NB = NV + 1;
  localparam int TB = NB - 1;

  logic [NB-1:0] stat_q, alt_q, mask_q, stat_nxt, alt_nxt;
  logic          hot_q, t_ev;

  wire gt_hot   = $signed(temp) > $signed(hot_lim);
  wire lt_hyst  = $signed(temp) < $signed(hyst_lim);
  wire cmp_mode = (temp_mode == 2'b10);
  wire one_mode = (temp_mode == 2'b01);

  always_comb begin
    if (cmp_mode)      t_ev = gt_hot;
    else if (one_mode) t_ev = (!hot_q && gt_hot) || (hot_q && lt_hyst && !gt_hot);
    else               t_ev = gt_hot || (hot_q && !lt_hyst);
  end

  wire [NB-1:0] ev     = meas_valid ? ({t_ev, volt_oor} & ~mask_q) : '0;
  wire [NB-1:0] rd_clr = stat_rd ? {~cmp_mode, {NV{1'b1}}} : '0;

  always_comb begin
    stat_nxt = ev | (stat_q & ~rd_clr);
    alt_nxt  = ev | (alt_q & ~rd_clr);
    if (cmp_mode && meas_valid) begin
      stat_nxt[TB] = ev[TB];
      alt_nxt[TB]  = ev[TB];
    end
    if (alert_clr) alt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      alt_q  <= '0;
      mask_q <= '0;
      hot_q  <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      alt_q  <= alt_nxt;
      if (mask_wr) mask_q <= mask_wdata;
      if (meas_valid) hot_q <= gt_hot ? 1'b1 : (lt_hyst ? 1'b0 : hot_q);
    end
  end

  assign status  = {{(SW-NB){1'b0}}, stat_q & ~mask_q};
  assign mask    = mask_q;
  assign alert_n = ~(alert_en && !alert_clr && |(alt_q & ~mask_q));
endmodule

// File: rtl/alert_status_chk.sv
module alert_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       meas_valid,
  input logic [7:0] temp,
  input logic [7:0] hot_lim,
  input logic [1:0] temp_mode,
  input logic       stat_rd,
  input logic       mask_wr,
  input logic       alert_en,
  input logic       alert_clr,
  input logic [7:0] status,
  input logic [4:0] mask,
  input logic       alert_n
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == 3'b000);

  assert_read_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !meas_valid && temp_mode != 2'b10 |=> status == 8'h00);

  assert_mask_hide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask[0] && !mask_wr |=> !status[0]);

  assert_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_en |-> alert_n);

  assert_clear_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr |-> alert_n);

  assert_clear_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr && !meas_valid && !stat_rd && !mask_wr |=> status == $past(status));

  assert_cmp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !meas_valid && !mask_wr && temp_mode == 2'b10 |=> status[4] == $past(status[4]));

  assert_cmp_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid && temp_mode == 2'b10 && !mask[4] && !mask_wr
      |=> status[4] == ($signed($past(temp)) > $signed($past(hot_lim))));
endmodule

bind alert_status_ctrl alert_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .temp(temp),
  .hot_lim(hot_lim), .temp_mode(temp_mode), .stat_rd(stat_rd),
  .mask_wr(mask_wr), .alert_en(alert_en), .alert_clr(alert_clr),
  .status(status), .mask(mask), .alert_n(alert_n)
);

// File: tb/tb_alert_status_ctrl.sv
module tb_alert_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, meas_valid, stat_rd, mask_wr, alert_en, alert_clr;
  logic [3:0] volt_oor;
  logic [7:0] temp, hot_lim, hyst_lim;
  logic [1:0] temp_mode;
  logic [4:0] mask_wdata;
  logic [7:0] status;
  logic [4:0] mask;
  logic       alert_n;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  alert_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .volt_oor(volt_oor),
    .temp(temp), .hot_lim(hot_lim), .hyst_lim(hyst_lim), .temp_mode(temp_mode),
    .stat_rd(stat_rd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .alert_en(alert_en), .alert_clr(alert_clr), .status(status), .mask(mask),
    .alert_n(alert_n)
  );

  // {meas, volt[3:0], temp[7:0], mode[1:0], rd, exp_status[4:0], exp_alert_n}
  localparam int NVEC = 34;
  localparam logic [21:0] VEC [0:NVEC-1] = '{
    {1'b1, 4'b0001, 8'd20, 2'd0, 1'b0, 5'b00001, 1'b0},  // R1
    {1'b0, 4'b0000, 8'd20, 2'd0, 1'b1, 5'b00000, 1'b1},  // R2
    {1'b1, 4'b1010, 8'd20, 2'd0, 1'b0, 5'b01010, 1'b0},  // R1
    {1'b1, 4'b0000, 8'd20, 2'd0, 1'b1, 5'b00000, 1'b1},  // R2
    {1'b1, 4'b0100, 8'd20, 2'd0, 1'b1, 5'b00100, 1'b0},  // R2 new fault wins
    {1'b0, 4'b0000, 8'd20, 2'd0, 1'b1, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd90, 2'd0, 1'b0, 5'b10000, 1'b0},  // R6
    {1'b0, 4'b0000, 8'd90, 2'd0, 1'b1, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd70, 2'd0, 1'b0, 5'b10000, 1'b0},  // R6 band re-raise
    {1'b0, 4'b0000, 8'd70, 2'd0, 1'b1, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd60, 2'd0, 1'b0, 5'b00000, 1'b1},  // R6 below hyst
    {1'b1, 4'b0000, 8'd70, 2'd0, 1'b0, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd90, 2'd1, 1'b0, 5'b10000, 1'b0},  // R7
    {1'b0, 4'b0000, 8'd90, 2'd1, 1'b1, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd95, 2'd1, 1'b0, 5'b00000, 1'b1},  // R7 no repeat
    {1'b1, 4'b0000, 8'd70, 2'd1, 1'b0, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd60, 2'd1, 1'b0, 5'b10000, 1'b0},  // R7 cold event
    {1'b0, 4'b0000, 8'd60, 2'd1, 1'b1, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd60, 2'd1, 1'b0, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd90, 2'd2, 1'b0, 5'b10000, 1'b0},  // R8
    {1'b0, 4'b0000, 8'd90, 2'd2, 1'b1, 5'b10000, 1'b0},  // R8 read keeps
    {1'b1, 4'b0000, 8'd81, 2'd2, 1'b0, 5'b10000, 1'b0},
    {1'b1, 4'b0000, 8'd80, 2'd2, 1'b0, 5'b00000, 1'b1},  // R8 equal to limit
    {1'b1, 4'b0000, 8'd70, 2'd2, 1'b0, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd60, 2'd3, 1'b0, 5'b00000, 1'b1},  // R9
    {1'b1, 4'b0000, 8'd90, 2'd3, 1'b0, 5'b10000, 1'b0},
    {1'b0, 4'b0000, 8'd90, 2'd3, 1'b1, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'd70, 2'd3, 1'b0, 5'b10000, 1'b0},  // R9 band re-raise
    {1'b1, 4'b0000, 8'd60, 2'd3, 1'b0, 5'b10000, 1'b0},
    {1'b0, 4'b0000, 8'd60, 2'd3, 1'b1, 5'b00000, 1'b1},
    {1'b1, 4'b0000, 8'hF0, 2'd0, 1'b0, 5'b00000, 1'b1},  // R6 signed
    {1'b1, 4'b0010, 8'd90, 2'd2, 1'b0, 5'b10010, 1'b0},
    {1'b0, 4'b0000, 8'd90, 2'd2, 1'b1, 5'b10000, 1'b0},  // R2 voltage cleared in cmp
    {1'b1, 4'b0000, 8'd20, 2'd2, 1'b0, 5'b00000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    meas_valid = 0; stat_rd = 0; mask_wr = 0; alert_clr = 0; volt_oor = '0;
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic meas(input logic [3:0] v, input logic [7:0] t);
    @(negedge clk); idle(); meas_valid = 1; volt_oor = v; temp = t;
    cyc(); @(negedge clk); idle();
  endtask

  task automatic mwr(input logic [4:0] d);
    @(negedge clk); idle(); mask_wr = 1; mask_wdata = d;
    cyc(); @(negedge clk); idle();
  endtask

  task automatic rd();
    @(negedge clk); idle(); stat_rd = 1;
    cyc(); @(negedge clk); idle();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(); rst_n = 0; alert_en = 1; temp = 8'd20; temp_mode = 2'd0;
    hot_lim = 8'd80; hyst_lim = 8'd65; mask_wdata = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R10 status", status, 8'h00);
    chk("R10 mask", mask, 5'h00);
    chk("R10 alert_n", alert_n, 1'b1);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {meas_valid, volt_oor, temp, temp_mode, stat_rd} = VEC[i][21:6];
      cyc();
      chk($sformatf("R1/R2/R6-R9 vec %0d status", i), status, {3'b000, VEC[i][5:1]});
      chk($sformatf("R4 vec %0d alert_n", i), alert_n, VEC[i][0]);
    end
    @(negedge clk); idle(); temp_mode = 2'd0;

    // R3: masked fault never latches
    mwr(5'b00001);
    chk("R3 mask readback", mask, 5'b00001);
    meas(4'b0001, 8'd20);
    chk("R3 masked status", status, 8'h00);
    chk("R3 masked alert", alert_n, 1'b1);
    mwr(5'b00000);
    chk("R3 unmask nothing stored", status, 8'h00);

    // R3: masking hides a latched bit
    meas(4'b0010, 8'd20);
    chk("R3 latched", status, 8'h02);
    mwr(5'b00010);
    chk("R3 hidden status", status, 8'h00);
    chk("R3 hidden alert", alert_n, 1'b1);
    mwr(5'b00000);
    chk("R3 reappears", status, 8'h02);
    chk("R3 alert back", alert_n, 1'b0);

    // R4: global enable
    @(negedge clk); alert_en = 0; #1;
    chk("R4 disabled alert", alert_n, 1'b1);
    cyc();
    chk("R4 status kept", status, 8'h02);
    @(negedge clk); alert_en = 1; #1;
    chk("R4 re-enabled alert", alert_n, 1'b0);

    // R5: alert clear keeps status
    @(negedge clk); alert_clr = 1; #1;
    chk("R5 clr during", alert_n, 1'b1);
    cyc();
    @(negedge clk); alert_clr = 0; #1;
    chk("R5 clr after", alert_n, 1'b1);
    chk("R5 status kept", status, 8'h02);
    rd();
    chk("R2 cleared", status, 8'h00);

    // R5/R8: comparator reassert after clear
    @(negedge clk); temp_mode = 2'd2;
    meas(4'b0000, 8'd90);
    chk("R8 set", status, 8'h10);
    chk("R8 alert", alert_n, 1'b0);
    @(negedge clk); alert_clr = 1; cyc(); @(negedge clk); idle(); #1;
    chk("R5 cmp cleared alert", alert_n, 1'b1);
    chk("R5 cmp status kept", status, 8'h10);
    meas(4'b0000, 8'd90);
    chk("R5 cmp reasserted", alert_n, 1'b0);
    meas(4'b0000, 8'd20);
    chk("R8 cooled status", status, 8'h00);
    chk("R8 cooled alert", alert_n, 1'b1);

    // R10: reset mid-run
    mwr(5'b11111);
    @(negedge clk); rst_n = 0; cyc();
    chk("R10 reset status", status, 8'h00);
    chk("R10 reset mask", mask, 5'h00);
    chk("R10 reset alert_n", alert_n, 1'b1);
    @(negedge clk); rst_n = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule